// File: doc/BRIEF.md
# Capture/Compare/PWM Channel

This block is one channel of a counter-array timer. A shared free-running counter outside the block supplies a 16-bit count, a one-cycle strobe marking each step of that count, and a strobe marking each time the count's low byte wraps to zero. The channel holds a mode register and a 16-bit capture/compare value, split into a low byte and a high byte. All of these registers are written and read one byte at a time.

Depending on its mode bits, the channel does one of the following:
- It latches the count when its input pin rises or falls, or both.
- It flags the cycle in which the count equals the compare value, and can also invert its output pin on that match.
- It drives 8-bit pulse-width modulation on its output pin. The duty value is double-buffered: the high byte reloads the low byte at each low-byte wrap.

Captures and matches set a sticky event flag. On an instance built with watchdog capability, a match while the watchdog enable is high requests a reset instead of setting the flag.

Top module: `ccp_chan`

## Requirements
- R1: After reset the mode register, both compare bytes and the event flag read 0, and pin_o and wdt_rst_o are 0.
- R2: With mode bit 0 set, a rising edge on pin_i is seen through a two-flop synchroniser. By the fourth clock edge after the change, the count at that edge is copied into the compare bytes ({high, low}), and the event flag is set.
- R3: With mode bit 1 set, a falling edge on pin_i captures the count in the same way. An edge of a kind whose capture bit is clear captures nothing.
- R4: A mode register write whose value differs from the current value discards edges that were seen but not yet captured. An edge that arrived while capture was off therefore never captures after capture is turned on.
- R5: While mode bit 2 (match flag) or bit 3 (match toggle) is set:
  - a write to the low compare byte (address 1) clears mode bit 5 (comparator enable);
  - a write to the high compare byte (address 2) sets mode bit 5.
- R6: With mode bit 5 set, a cycle with cnt_adv_i high and cnt_i equal to {high, low} sets the event flag. A mismatching count, or a cycle without cnt_adv_i, does not set it.
- R7: With mode bit 3 set and mode bit 4 clear, each such match inverts pin_o one edge later. Otherwise pin_o holds its value.
- R8: When WDT_CAP is 1 and wdt_en_i is high, a match produces a single-cycle pulse on wdt_rst_o one edge later. In that case the event flag is not set and pin_o does not toggle.
- R9: With mode bit 4 (PWM) set, wrap_i copies the high compare byte into the low byte. pin_o is 0 while cnt_i[7:0] is below the low byte and 1 otherwise. Writing the high byte leaves the low byte unchanged until a wrap occurs.
- R10: The event flag at address 3, bit 0, is sticky. Writing 0 to bit 0 clears it and writing 1 has no effect. A capture or match in the same cycle as a clearing write leaves the flag set.
- R11: Register read map on rd_addr_i:
  - address 0 reads the mode register, with bits 5:0 as above and bits 7:6 reading 0;
  - address 1 reads the low compare byte;
  - address 2 reads the high compare byte;
  - address 3 reads the flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Shared counter value |
| cnt_adv_i | input | 1 | Counter took a new value this cycle |
| wrap_i | input | 1 | Counter low byte wrapped to zero |
| pin_i | input | 1 | Capture input pin, asynchronous |
| wdt_en_i | input | 1 | Watchdog enable from the shared configuration |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | CNT_W/2 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | CNT_W/2 | Register read data, combinational |
| pin_o | output | 1 | Toggle or PWM output pin |
| flag_o | output | 1 | Sticky event flag |
| wdt_rst_o | output | 1 | Watchdog reset request pulse |

## Verification
The bench builds the channel with CNT_W=16, SYNC_STAGES=2 and WDT_CAP=1. With WDT_CAP=1, driving wdt_en_i alone chooses between the reset-request path and the normal flag path on the same instance, so both outcomes of a match are checked. The 16-bit count lets directed equal and off-by-one compare values exercise the full-width comparator. The two-stage synchroniser fixes the capture latency that the edge tests sample against. Random counts and duty values check the PWM output and the toggle sequence against bench models.

// File: rtl/ccp_pkg.sv
`timescale 1ns/1ps
package ccp_pkg;
  localparam int MODE_W   = 6;
  localparam int MB_RISE  = 0;
  localparam int MB_FALL  = 1;
  localparam int MB_MATCH = 2;
  localparam int MB_TOG   = 3;
  localparam int MB_PWM   = 4;
  localparam int MB_CMP   = 5;

  typedef enum logic [1:0] {
    ADR_MODE  = 2'd0,
    ADR_CAPLO = 2'd1,
    ADR_CAPHI = 2'd2,
    ADR_FLAG  = 2'd3
  } ccp_adr_e;
endpackage

// File: rtl/ccp_edge.sv
`timescale 1ns/1ps
module ccp_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic clr_i,
  input  logic take_i,
  output logic rise_o,
  output logic fall_o
);
  // sh_q[SYNC_STAGES-1] is the synchronised pin, sh_q[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] sh_q;
  logic sync_cur, sync_prev, rise_ev, fall_ev;
  logic rise_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], pin_i};
  end

  assign sync_cur  = sh_q[SYNC_STAGES-1];
  assign sync_prev = sh_q[SYNC_STAGES];
  assign rise_ev   = sync_cur & ~sync_prev;
  assign fall_ev   = ~sync_cur & sync_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (clr_i) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      if (take_i) begin
        rise_q <= 1'b0;
        fall_q <= 1'b0;
      end
      if (rise_ev) rise_q <= 1'b1;
      if (fall_ev) fall_q <= 1'b1;
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;

  // R4
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!rise_o && !fall_o));
endmodule

// File: rtl/ccp_cmp.sv
`timescale 1ns/1ps
module ccp_cmp #(
  parameter int CNT_W   = 16,
  parameter bit WDT_CAP = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             arm_i,
  input  logic             adv_i,
  input  logic             tog_en_i,
  input  logic             wdt_en_i,
  output logic             flag_set_o,
  output logic             tog_o,
  output logic             wdt_rst_o
);
  logic hit, wdt_sel;
  logic tog_q, wdt_q;

  assign hit = arm_i & adv_i & (cnt_i == cmp_i);

  generate
    if (WDT_CAP) begin : g_wdt
      assign wdt_sel = wdt_en_i;
    end else begin : g_no_wdt
      assign wdt_sel = 1'b0;
    end
  endgenerate

  assign flag_set_o = hit & ~wdt_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q <= 1'b0;
      wdt_q <= 1'b0;
    end else begin
      wdt_q <= hit & wdt_sel;
      if (hit && !wdt_sel && tog_en_i) tog_q <= ~tog_q;
    end
  end

  assign tog_o     = tog_q;
  assign wdt_rst_o = wdt_q;

  // R7
  tog_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !wdt_sel && tog_en_i) |=> (tog_o != $past(tog_o)));
  // R7
  tog_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(tog_o));
  // R8
  wdt_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && wdt_sel) |=> wdt_rst_o);
  // R8
  wdt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit && wdt_sel) |=> !wdt_rst_o);
endmodule

// File: rtl/ccp_pwm.sv
`timescale 1ns/1ps
module ccp_pwm #(
  parameter int DUTY_W = 8
) (
  input  logic              pwm_en_i,
  input  logic [DUTY_W-1:0] cnt_lo_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              tog_i,
  output logic              pin_o
);
  always_comb begin
    if (pwm_en_i) pin_o = (cnt_lo_i < duty_i) ? 1'b0 : 1'b1;
    else          pin_o = tog_i;
  end
endmodule

// File: rtl/ccp_chan.sv
`timescale 1ns/1ps
module ccp_chan
  import ccp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit WDT_CAP     = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               cnt_adv_i,
  input  logic               wrap_i,
  input  logic               pin_i,
  input  logic               wdt_en_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [CNT_W/2-1:0] wr_data_i,
  input  logic [1:0]         rd_addr_i,
  output logic [CNT_W/2-1:0] rd_data_o,
  output logic               pin_o,
  output logic               flag_o,
  output logic               wdt_rst_o
);
  localparam int BYTE_W = CNT_W / 2;

  logic [MODE_W-1:0] mode_q;
  logic [BYTE_W-1:0] cap_lo_q, cap_hi_q;
  logic              flag_q;

  logic wr_mode, wr_lo, wr_hi, wr_flag, mode_chg, arm_mode;
  logic rise_pend, fall_pend, cap_go;
  logic match_set, tog, set_ev;

  assign wr_mode  = wr_en_i && (wr_addr_i == ADR_MODE);
  assign wr_lo    = wr_en_i && (wr_addr_i == ADR_CAPLO);
  assign wr_hi    = wr_en_i && (wr_addr_i == ADR_CAPHI);
  assign wr_flag  = wr_en_i && (wr_addr_i == ADR_FLAG);
  assign mode_chg = wr_mode && (wr_data_i[MODE_W-1:0] != mode_q);
  assign arm_mode = mode_q[MB_MATCH] | mode_q[MB_TOG];

  ccp_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .clr_i  (mode_chg),
    .take_i (cap_go),
    .rise_o (rise_pend),
    .fall_o (fall_pend)
  );

  // capture suppressed in the cycle a mode change discards pending edges
  assign cap_go = ~mode_chg &
                  ((rise_pend & mode_q[MB_RISE]) | (fall_pend & mode_q[MB_FALL]));

  ccp_cmp #(.CNT_W(CNT_W), .WDT_CAP(WDT_CAP)) i_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt_i),
    .cmp_i      ({cap_hi_q, cap_lo_q}),
    .arm_i      (mode_q[MB_CMP]),
    .adv_i      (cnt_adv_i),
    .tog_en_i   (mode_q[MB_TOG]),
    .wdt_en_i   (wdt_en_i),
    .flag_set_o (match_set),
    .tog_o      (tog),
    .wdt_rst_o  (wdt_rst_o)
  );

  ccp_pwm #(.DUTY_W(BYTE_W)) i_pwm (
    .pwm_en_i (mode_q[MB_PWM]),
    .cnt_lo_i (cnt_i[BYTE_W-1:0]),
    .duty_i   (cap_lo_q),
    .tog_i    (tog),
    .pin_o    (pin_o)
  );

  assign set_ev = cap_go | match_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (wr_mode) begin
      mode_q <= wr_data_i[MODE_W-1:0];
    end else if (wr_lo && arm_mode) begin
      mode_q[MB_CMP] <= 1'b0;
    end else if (wr_hi && arm_mode) begin
      mode_q[MB_CMP] <= 1'b1;
    end
  end

  // priority: software write, then capture, then PWM reload
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_lo_q <= '0;
      cap_hi_q <= '0;
    end else begin
      if (wr_lo)                         cap_lo_q <= wr_data_i;
      else if (cap_go)                   cap_lo_q <= cnt_i[BYTE_W-1:0];
      else if (mode_q[MB_PWM] && wrap_i) cap_lo_q <= cap_hi_q;
      if (wr_hi)       cap_hi_q <= wr_data_i;
      else if (cap_go) cap_hi_q <= cnt_i[CNT_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       flag_q <= 1'b0;
    else if (set_ev)                   flag_q <= 1'b1;
    else if (wr_flag && !wr_data_i[0]) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  always_comb begin
    unique case (rd_addr_i)
      ADR_MODE:  rd_data_o = {{(BYTE_W-MODE_W){1'b0}}, mode_q};
      ADR_CAPLO: rd_data_o = cap_lo_q;
      ADR_CAPHI: rd_data_o = cap_hi_q;
      default:   rd_data_o = {{(BYTE_W-1){1'b0}}, flag_q};
    endcase
  end

  // R2
  cap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_go && !wr_lo && !wr_hi) |=> ({cap_hi_q, cap_lo_q} == $past(cnt_i)));
  // R5
  disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo && arm_mode) |=> !mode_q[MB_CMP]);
  // R5
  arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi && arm_mode) |=> mode_q[MB_CMP]);
  // R9
  pwm_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[MB_PWM] && wrap_i && !wr_lo && !cap_go) |=> (cap_lo_q == $past(cap_hi_q)));
  // R10
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ev |=> flag_o);
  // R10
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_flag && !wr_data_i[0] && !set_ev) |=> !flag_o);
endmodule

// File: tb/test_ccp_chan.sv
`timescale 1ns/1ps
module test_ccp_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic        adv = 1'b0, wrap = 1'b0, pin_in = 1'b0, wdt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        pin_out, flag, wdt_rst;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ccp_chan #(.CNT_W(16), .SYNC_STAGES(2), .WDT_CAP(1'b1)) i_ccp_chan (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_adv_i(adv), .wrap_i(wrap),
    .pin_i(pin_in), .wdt_en_i(wdt_en), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pin_o(pin_out), .flag_o(flag), .wdt_rst_o(wdt_rst)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic pwm_exp(input logic [7:0] c, input logic [7:0] duty);
    return (c < duty) ? 1'b0 : 1'b1;
  endfunction

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] duty, hi;
    logic exp_tog, exp_flag;
    void'($urandom(32'd1234));
    wait_cyc(3);
    // R1 reset state
    rd(2'd0, v); chk("R1 mode", v, 0);
    rd(2'd1, v); chk("R1 lo", v, 0);
    rd(2'd2, v); chk("R1 hi", v, 0);
    rd(2'd3, v); chk("R1 flag", v, 0);
    chk("R1 pin", pin_out, 0);
    chk("R1 wdt", wdt_rst, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 rising capture
    wr(2'd0, 8'h01);
    rd(2'd0, v); chk("R11 mode read", v, 8'h01);
    cnt = 16'h1234; pin_in = 1'b1;
    wait_cyc(6);
    rd(2'd1, v); chk("R2 cap lo", v, 8'h34);
    rd(2'd2, v); chk("R2 cap hi", v, 8'h12);
    chk("R2 flag", flag, 1);

    // R10 clear, write-one ignored
    wr(2'd3, 8'h00); chk("R10 clear", flag, 0);
    wr(2'd3, 8'h01); chk("R10 write one", flag, 0);

    // R3 falling edge ignored with rise-only mode
    cnt = 16'h5678; pin_in = 1'b0;
    wait_cyc(6);
    rd(2'd1, v); chk("R3 fall ignored lo", v, 8'h34);
    chk("R3 fall ignored flag", flag, 0);
    wr(2'd0, 8'h02);
    pin_in = 1'b1; wait_cyc(6);
    chk("R3 rise ignored flag", flag, 0);
    cnt = 16'h9abc; pin_in = 1'b0; wait_cyc(6);
    rd(2'd1, v); chk("R3 fall cap lo", v, 8'hbc);
    rd(2'd2, v); chk("R3 fall cap hi", v, 8'h9a);
    chk("R3 fall flag", flag, 1);
    wr(2'd3, 8'h00);

    // R4 edge seen while disabled is discarded by a mode change
    wr(2'd0, 8'h00);
    cnt = 16'h0f0f; pin_in = 1'b1; wait_cyc(6);
    wr(2'd0, 8'h01);
    wait_cyc(6);
    chk("R4 no stale capture flag", flag, 0);
    rd(2'd1, v); chk("R4 no stale capture lo", v, 8'hbc);
    pin_in = 1'b0; wait_cyc(6);

    // R5 arming by compare byte writes
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h10);
    rd(2'd0, v); chk("R5 lo disarms", v, 8'h04);
    wr(2'd2, 8'h20);
    rd(2'd0, v); chk("R5 hi arms", v, 8'h24);

    // R6 match
    @(negedge clk); cnt = 16'h2011; adv = 1'b1;
    @(negedge clk); adv = 1'b0; chk("R6 mismatch", flag, 0);
    cnt = 16'h2010;
    @(negedge clk); chk("R6 no advance", flag, 0);
    adv = 1'b1;
    @(negedge clk); adv = 1'b0; chk("R6 match flag", flag, 1);
    // R10 set wins over clear
    wr(2'd3, 8'h00);
    @(negedge clk); adv = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h00;
    @(negedge clk); adv = 1'b0; wr_en = 1'b0; chk("R10 set wins", flag, 1);
    wr(2'd3, 8'h00);

    // R7 toggle
    wr(2'd0, 8'h28);
    chk("R7 pin before", pin_out, 0);
    @(negedge clk); adv = 1'b1;
    @(negedge clk); adv = 1'b0; chk("R7 toggle 1", pin_out, 1);
    @(negedge clk); adv = 1'b1;
    @(negedge clk); adv = 1'b0; chk("R7 toggle 0", pin_out, 0);
    wr(2'd3, 8'h00);

    // R8 watchdog request
    wdt_en = 1'b1;
    @(negedge clk); adv = 1'b1;
    @(negedge clk); adv = 1'b0;
    chk("R8 wdt pulse", wdt_rst, 1);
    chk("R8 no flag", flag, 0);
    chk("R8 no toggle", pin_out, 0);
    @(negedge clk); chk("R8 pulse ends", wdt_rst, 0);
    wdt_en = 1'b0;

    // R9 PWM
    wr(2'd0, 8'h10);
    wr(2'd2, 8'h80);
    rd(2'd1, v); chk("R9 no reload without wrap", v, 8'h10);
    @(negedge clk); wrap = 1'b1;
    @(negedge clk); wrap = 1'b0;
    rd(2'd1, v); chk("R9 reload", v, 8'h80);
    duty = 8'h80;
    for (int i = 0; i < 300; i++) begin
      if (i % 8 == 7) begin
        hi = 8'($urandom);
        if (i % 32 == 7) hi = 8'h00;
        if (i % 32 == 15) hi = 8'hff;
        wr(2'd2, hi);
        @(negedge clk); wrap = 1'b1;
        @(negedge clk); wrap = 1'b0;
        duty = hi;
      end
      cnt = 16'($urandom);
      if (i % 5 == 0) cnt[7:0] = duty;
      #1;
      chk("R9 pwm pin", pin_out, pwm_exp(cnt[7:0], duty));
    end

    // random toggle/match run
    wr(2'd0, 8'h08);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h5a);
    wr(2'd2, 8'ha5);
    rd(2'd0, v); chk("R5 tog mode arms", v, 8'h28);
    exp_tog = pin_out;
    exp_flag = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      cnt = ($urandom % 3 == 0) ? 16'ha55a : 16'($urandom);
      adv = 1'($urandom);
      @(negedge clk);
      if (adv && cnt == 16'ha55a) begin
        exp_tog = ~exp_tog;
        exp_flag = 1'b1;
      end
      adv = 1'b0;
      chk("R7 random toggle", pin_out, exp_tog);
      chk("R6 random flag", flag, exp_flag);
      if (i % 16 == 0) begin
        wr(2'd3, 8'h00);
        exp_flag = 1'b0;
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule